// File: doc/BRIEF.md
# Bus Reset Qualifier and Power-On Configuration Sequencer

This block watches an asynchronous, active-high bus reset and turns it into the internal reset phases of a controller. It first brings the reset into the clock domain through a synchronizer. It then measures how long the reset stays high. A pulse shorter than a quiet threshold (415 ns) leaves every output untouched. A pulse that reaches the quiet threshold disables the controller's outputs and enables weak pull-downs on the strap pins. A reset held for the power-on threshold (415 µs) is treated as a power-on reset and opens a register-load window.

When a power-on reset is released, the block captures the strap pins into its configuration register. One clock later it closes the register-load window, fires a one-cycle start pulse to an external serial-EEPROM loader and reports busy. Busy clears when the loader signals completion, or when a 320 µs limit expires. When the loader completes and the EEPROM-config select is high, the loader's configuration word replaces the captured strap value.

All three time limits are given in nanoseconds. They are converted to clock cycles from a clock-frequency parameter, and each count is rounded up.

Top module: `rst_qual_seq`

## Requirements
- R1: A reset that is high for fewer than QUIET cycles (ceil(415 ns × clock MHz), 52 at 125 MHz) causes no change on any output.
- R2: A reset high for L ≥ QUIET cycles drives `out_dis_o` high for exactly L − QUIET + 1 cycles.
- R3: A qualified reset shorter than POR cycles (ceil(415 µs × clock MHz)) returns to idle with no register-load, no start pulse, no busy and an unchanged `cfg_o`.
- R4: A reset high for L ≥ POR cycles drives `regload_o` high for exactly L − POR + 2 cycles, which ends one clock after the synchronized reset falls.
- R5: When a power-on reset is released, `cfg_o` takes the value of `cfg_pins_i` sampled on the first clock at which the synchronized reset is low.
- R6: Each power-on reset produces exactly one single-cycle `load_start_o` pulse, on the cycle after `regload_o` falls. `busy_o` is high during that pulse.
- R7: `busy_o` rises on the release clock and falls on the clock after `load_done_i` is sampled high during the boot load.
- R8: Without `load_done_i`, `busy_o` stays high for exactly LOAD + 1 cycles (ceil(320 µs × clock MHz) boot cycles plus the release cycle).
- R9: A load completion with `ee_sel_i` high replaces `cfg_o` with `ee_cfg_i`. With `ee_sel_i` low, or on a timeout, the strap value is kept.
- R10: A `load_done_i` pulse outside a boot load has no effect: `cfg_o` is unchanged and `busy_o` stays low.
- R11: `pd_en_o` is high whenever `out_dis_o` is high, and stays high for the one release cycle after a power-on reset. `out_dis_o` and `busy_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| bus_rst_i | input | 1 | Asynchronous active-high bus reset being qualified |
| cfg_pins_i | input | CFG_W | Strap pin values |
| ee_sel_i | input | 1 | High: EEPROM config overrides the straps at load completion |
| ee_cfg_i | input | CFG_W | Configuration word from the loader, valid with `load_done_i` |
| load_done_i | input | 1 | Loader completion strobe |
| out_dis_o | output | 1 | Disable all controller outputs |
| pd_en_o | output | 1 | Enable weak pull-downs on the strap pins |
| regload_o | output | 1 | Power-on register-load window |
| cfg_o | output | CFG_W | Latched configuration |
| load_start_o | output | 1 | One-cycle start for the EEPROM loader |
| busy_o | output | 1 | Device inaccessible |

## Verification
A width counter that is off by one shows directly as a wrong count of `out_dis_o` or `regload_o` cycles for a pulse at exactly the threshold, or one cycle short of it. The check therefore counts output cycles per reset pulse rather than sampling at fixed times. A state machine stuck in the wrong phase shows within one clock as a missing or doubled start pulse, or as busy overlapping output-disable. A wrong timeout value shows only at the end of a boot load, as a busy length different from LOAD + 1. A wrong latch or override path shows on `cfg_o` once the window closes.

// File: rtl/rqs_pkg.sv
package rqs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_QUIET = 3'd1,
    ST_POR   = 3'd2,
    ST_REL   = 3'd3,
    ST_BOOT  = 3'd4
  } rqs_state_e;

  // ceil(ns * MHz / 1000)
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/rqs_sync.sv
module rqs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain = '0;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk) chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rqs_width_timer.sv
module rqs_width_timer #(
  parameter int unsigned QUIET_CYC = 52,
  parameter int unsigned POR_CYC   = 51875
) (
  input  logic clk,
  input  logic rst_s_i,
  output logic quiet_hit_o,
  output logic por_hit_o
);
  localparam int CW = $clog2(POR_CYC + 1);
  localparam logic [CW-1:0] QUIET_LAST = CW'(QUIET_CYC - 1);
  localparam logic [CW-1:0] POR_LAST   = CW'(POR_CYC - 1);
  localparam logic [CW-1:0] SAT        = CW'(POR_CYC);

  logic [CW-1:0] cnt = '0;

  always_ff @(posedge clk) begin
    if (!rst_s_i)
      cnt <= '0;
    else if (cnt != SAT)
      cnt <= cnt + 1'b1;
  end

  // asserted on the sample that completes the threshold
  assign quiet_hit_o = rst_s_i && (cnt == QUIET_LAST);
  assign por_hit_o   = rst_s_i && (cnt == POR_LAST);
endmodule

// File: rtl/rqs_boot_timer.sv
module rqs_boot_timer #(
  parameter int unsigned LOAD_CYC = 40000
) (
  input  logic clk,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LOAD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(LOAD_CYC - 1);

  logic [CW-1:0] cnt = '0;

  always_ff @(posedge clk) begin
    if (!run_i)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  assign expired_o = run_i && (cnt == LAST);
endmodule

// File: rtl/rqs_cfg_store.sv
module rqs_cfg_store #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             strap_en_i,
  input  logic [CFG_W-1:0] strap_i,
  input  logic             ovw_en_i,
  input  logic [CFG_W-1:0] ovw_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] cfg_q = '0;

  always_ff @(posedge clk) begin
    if (strap_en_i)
      cfg_q <= strap_i;
    else if (ovw_en_i)
      cfg_q <= ovw_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/rst_qual_seq.sv
module rst_qual_seq
  import rqs_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 125,
  parameter int unsigned QUIET_NS  = 415,
  parameter int unsigned POR_NS    = 415000,
  parameter int unsigned LOAD_NS   = 320000,
  parameter int          SYNC_STG  = 2,
  parameter int          CFG_W     = 8
) (
  input  logic             clk,
  input  logic             bus_rst_i,
  input  logic [CFG_W-1:0] cfg_pins_i,
  input  logic             ee_sel_i,
  input  logic [CFG_W-1:0] ee_cfg_i,
  input  logic             load_done_i,
  output logic             out_dis_o,
  output logic             pd_en_o,
  output logic             regload_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             load_start_o,
  output logic             busy_o
);
  localparam int unsigned QUIET_CYC = ns_to_cycles(QUIET_NS, CLK_MHZ);
  localparam int unsigned POR_CYC   = ns_to_cycles(POR_NS, CLK_MHZ);
  localparam int unsigned LOAD_CYC  = ns_to_cycles(LOAD_NS, CLK_MHZ);

  logic rst_s;
  logic quiet_hit, por_hit, boot_exp;
  logic take_done, strap_en, ovw_en;
  rqs_state_e st = ST_IDLE;
  rqs_state_e st_n;

  logic dis_q = 1'b0, pd_q = 1'b0, rl_q = 1'b0, start_q = 1'b0, busy_q = 1'b0;

  rqs_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .d_i (bus_rst_i),
    .q_o (rst_s)
  );

  rqs_width_timer #(.QUIET_CYC(QUIET_CYC), .POR_CYC(POR_CYC)) u_wtmr (
    .clk         (clk),
    .rst_s_i     (rst_s),
    .quiet_hit_o (quiet_hit),
    .por_hit_o   (por_hit)
  );

  rqs_boot_timer #(.LOAD_CYC(LOAD_CYC)) u_btmr (
    .clk       (clk),
    .run_i     (st == ST_BOOT),
    .expired_o (boot_exp)
  );

  assign take_done = (st == ST_BOOT) && !quiet_hit && load_done_i;
  assign strap_en  = (st == ST_POR) && !rst_s;
  assign ovw_en    = take_done && ee_sel_i;

  rqs_cfg_store #(.CFG_W(CFG_W)) u_cfg (
    .clk        (clk),
    .strap_en_i (strap_en),
    .strap_i    (cfg_pins_i),
    .ovw_en_i   (ovw_en),
    .ovw_i      (ee_cfg_i),
    .cfg_o      (cfg_o)
  );

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE:  if (quiet_hit) st_n = ST_QUIET;
      ST_QUIET: if (!rst_s) st_n = ST_IDLE;
                else if (por_hit) st_n = ST_POR;
      ST_POR:   if (!rst_s) st_n = ST_REL;
      ST_REL:   st_n = ST_BOOT;
      ST_BOOT:  if (quiet_hit) st_n = ST_QUIET;
                else if (take_done || boot_exp) st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    st      <= st_n;
    dis_q   <= (st_n == ST_QUIET) || (st_n == ST_POR);
    pd_q    <= (st_n == ST_QUIET) || (st_n == ST_POR) || (st_n == ST_REL);
    rl_q    <= (st_n == ST_POR) || (st_n == ST_REL);
    busy_q  <= (st_n == ST_REL) || (st_n == ST_BOOT);
    start_q <= (st == ST_REL) && (st_n == ST_BOOT);
  end

  assign out_dis_o    = dis_q;
  assign pd_en_o      = pd_q;
  assign regload_o    = rl_q;
  assign load_start_o = start_q;
  assign busy_o       = busy_q;
endmodule

// File: rtl/rqs_checker.sv
module rqs_checker #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             out_dis_o,
  input logic             pd_en_o,
  input logic             regload_o,
  input logic [CFG_W-1:0] cfg_o,
  input logic             load_start_o,
  input logic             busy_o
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  AST_PD_WITH_DIS: assert property (@(posedge clk) disable iff (!armed)
    out_dis_o |-> pd_en_o);  // R11
  AST_DIS_BUSY_EXCL: assert property (@(posedge clk) disable iff (!armed)
    !(out_dis_o && busy_o));  // R11
  AST_RL_NEEDS_DIS: assert property (@(posedge clk) disable iff (!armed)
    $rose(regload_o) |-> out_dis_o);  // R4
  AST_RL_ONE_AFTER: assert property (@(posedge clk) disable iff (!armed)
    (regload_o && !out_dis_o) |=> !regload_o);  // R4
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!armed)
    load_start_o |=> !load_start_o);  // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!armed)
    load_start_o |-> (busy_o && !regload_o));  // R6
  AST_START_AFTER_RL: assert property (@(posedge clk) disable iff (!armed)
    $fell(regload_o) |-> load_start_o);  // R6
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!armed)
    (!regload_o && !busy_o) |=> $stable(cfg_o));  // R10
endmodule

bind rst_qual_seq rqs_checker #(.CFG_W(CFG_W)) u_rqs_checker (
  .clk          (clk),
  .out_dis_o    (out_dis_o),
  .pd_en_o      (pd_en_o),
  .regload_o    (regload_o),
  .cfg_o        (cfg_o),
  .load_start_o (load_start_o),
  .busy_o       (busy_o)
);

// File: tb/test_rst_qual_seq.sv
module test_rst_qual_seq;
  localparam int CW = 8;
  localparam int Q  = 52;   // ceil(415 ns * 125 MHz)
  localparam int P  = 519;  // ceil(4150 ns * 125 MHz)
  localparam int LD = 400;  // ceil(3200 ns * 125 MHz)

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          bus_rst = 1'b0, ee_sel = 1'b0, done = 1'b0;
  logic [CW-1:0] pins = '0, ee_cfg = '0;
  logic          out_dis, pd_en, regload, start, busy;
  logic [CW-1:0] cfg;

  rst_qual_seq #(.CLK_MHZ(125), .QUIET_NS(415), .POR_NS(4150),
                 .LOAD_NS(3200), .SYNC_STG(2), .CFG_W(CW)) i_rst_qual_seq (
    .clk(clk), .bus_rst_i(bus_rst), .cfg_pins_i(pins), .ee_sel_i(ee_sel),
    .ee_cfg_i(ee_cfg), .load_done_i(done), .out_dis_o(out_dis),
    .pd_en_o(pd_en), .regload_o(regload), .cfg_o(cfg),
    .load_start_o(start), .busy_o(busy)
  );

  typedef struct {
    int            dis, pd, rl, bsy, st;
    logic [CW-1:0] cfg;
    string         tag;
  } exp_t;

  exp_t          sb[$];
  int            n_vec = 0, n_bad = 0;
  int            c_dis = 0, c_pd = 0, c_rl = 0, c_bsy = 0, c_st = 0;
  logic          win_end = 1'b0;
  logic [CW-1:0] model_cfg = '0;
  bit            finished = 1'b0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: accumulate output cycles per window, compare at window end
  always @(negedge clk) begin
    if (win_end) begin
      if (sb.size() == 0) begin
        chk("R1", "scoreboard empty", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "out_dis cycles", c_dis, e.dis);
        chk(e.tag, "pd_en cycles",   c_pd,  e.pd);
        chk(e.tag, "regload cycles", c_rl,  e.rl);
        chk(e.tag, "busy cycles",    c_bsy, e.bsy);
        chk(e.tag, "start pulses",   c_st,  e.st);
        chk(e.tag, "cfg value",      int'(cfg), int'(e.cfg));
      end
      c_dis = 0; c_pd = 0; c_rl = 0; c_bsy = 0; c_st = 0;
    end else begin
      c_dis += int'(out_dis);
      c_pd  += int'(pd_en);
      c_rl  += int'(regload);
      c_bsy += int'(busy);
      c_st  += int'(start);
    end
  end

  // driver: one reset pulse of len cycles (0 = none), optional done strobe
  task automatic run_case(input int len, input bit use_done, input int dly,
                          input bit sel, input logic [CW-1:0] p,
                          input logic [CW-1:0] ee, input string tag);
    exp_t e;
    e.tag = tag;
    e.dis = (len >= Q) ? len - Q + 1 : 0;
    e.pd  = e.dis + ((len >= P) ? 1 : 0);
    e.rl  = (len >= P) ? len - P + 2 : 0;
    e.st  = (len >= P) ? 1 : 0;
    e.bsy = (len >= P) ? (use_done ? 2 + dly : LD + 1) : 0;
    if (len >= P) model_cfg = (use_done && sel) ? ee : p;
    e.cfg = model_cfg;
    sb.push_back(e);

    pins = p; ee_sel = sel; ee_cfg = ee;
    @(posedge clk); #1;
    if (len > 0) begin
      bus_rst = 1'b1;
      repeat (len) @(posedge clk);
      #1 bus_rst = 1'b0;
    end
    if (len >= P) begin
      @(negedge clk);
      while (!start) @(negedge clk);
      if (use_done) begin
        repeat (dly) @(posedge clk);
        #1 done = 1'b1;
        @(posedge clk); #1 done = 1'b0;
      end
      repeat (LD + 20) @(posedge clk);
    end else if (use_done) begin
      repeat (3) @(posedge clk);
      #1 done = 1'b1;
      @(posedge clk); #1 done = 1'b0;
      repeat (5) @(posedge clk);
    end else begin
      repeat (10) @(posedge clk);
    end
    @(posedge clk); #1 win_end = 1'b1;
    @(posedge clk); #1 win_end = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    // R1 reset state: nothing asserted before any qualified reset
    chk("R1", "idle out_dis", int'(out_dis), 0);
    chk("R1", "idle busy",    int'(busy),    0);
    chk("R1", "idle regload", int'(regload), 0);
    chk("R1", "idle start",   int'(start),   0);
    // R4 R5 R6 R8: power-on reset, strap capture, timeout
    run_case(P + 10, 1'b0, 0,  1'b0, 8'hA5, 8'h00, "R8");
    // R1: one cycle short of the quiet threshold
    run_case(Q - 1,  1'b0, 0,  1'b0, 8'h5A, 8'h00, "R1");
    // R2 R3: exactly at the quiet threshold and above it
    run_case(Q,      1'b0, 0,  1'b0, 8'h5A, 8'h00, "R2");
    run_case(Q + 30, 1'b0, 0,  1'b0, 8'h5A, 8'h00, "R3");
    // R3: one cycle short of power-on
    run_case(P - 1,  1'b0, 0,  1'b0, 8'h5A, 8'h00, "R3");
    // R5 R7: exactly at power-on threshold, done with select low
    run_case(P,      1'b1, 3,  1'b0, 8'h3C, 8'hFF, "R7");
    // R9: done with select high overrides the straps
    run_case(P + 5,  1'b1, 10, 1'b1, 8'h42, 8'hE7, "R9");
    // R10: stray done outside a boot load
    run_case(0,      1'b1, 0,  1'b1, 8'h99, 8'h11, "R10");
    // R9 R11: select high but timeout keeps straps
    run_case(P + 2,  1'b0, 0,  1'b1, 8'h81, 8'h22, "R11");
    chk("R6", "scoreboard drained", sb.size(), 0);
    summary();
  end
endmodule